// File: doc/BRIEF.md
# Bounds-Checked Legacy Video Memory Mapper

This block sits between a host that makes byte accesses into a legacy graphics window and a 32-bit-wide video RAM organised as four byte planes. For each request it turns the host address into a RAM word index and byte lane. Three addressing schemes are supported: a linear chained scheme, an interleaved odd/even scheme for text-style layouts, and a planar scheme in which one host address selects a whole 32-bit word. The active scheme comes from mode bits that the surrounding register file supplies.

Every translated location is compared against the configured RAM size. A read that lands outside the RAM returns 0xFF. A write that lands outside the RAM is dropped, so an oversized address never wraps onto low memory. A planar read also loads the full word into a 32-bit latch, which is visible at the ports. A planar write stores the host byte into every plane whose write enable is set. The RAM sits inside the block and is built so that block RAM can be inferred.

Top module: `vga_mem_mapper`

## Requirements
- R1: Mode priority: when `chain4_en` is 1, chained addressing is used whatever `oddeven_en` is. Otherwise odd/even addressing is used when `oddeven_en` is 1. Otherwise planar addressing is used.
- R2: Chained mode: the RAM byte address equals `req_addr`, which is word `req_addr>>2` and lane `req_addr[1:0]`. A write stores `req_wdata` only when `plane_we[req_addr[1:0]]` is 1.
- R3: Odd/even read: the plane is `{read_map[1], req_addr[0]}`. The byte address is `(req_addr with bit 0 cleared) * 2 + plane`.
- R4: Odd/even write: the plane is `{1'b0, req_addr[0]}`, with the same address formula as R3. The write happens only when `plane_we[req_addr[0]]` is 1.
- R5: Planar read: `req_addr` is a word index. The latch takes the whole word, with RAM byte `4*req_addr+k` in bits `8k+7:8k`. `rd_data` is latch byte `read_map`.
- R6: Planar write: `req_wdata` is written to byte `k` of word `req_addr` for each `k` where `plane_we[k]` is 1. The other bytes keep their values.
- R7: A read whose byte address is not below `RAM_BYTES` returns `rd_data` = 0xFF. In planar mode this happens when `4*req_addr >= RAM_BYTES`. Such a read leaves the latch unchanged.
- R8: A write whose byte address is not below `RAM_BYTES` changes no RAM location.
- R9: `rd_valid` is 1 in exactly the cycle after each read request. `rd_data` and `latch` reflect that read in the same cycle. `rd_valid` is 0 in all other cycles.
- R10: After reset `rd_valid` is 0 and `latch` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain4_en | input | 1 | Selects chained addressing |
| oddeven_en | input | 1 | Selects odd/even addressing when chained is off |
| read_map | input | 2 | Plane selected for reads |
| plane_we | input | 4 | Per-plane write enables |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host address within the window |
| req_wdata | input | 8 | Write data byte |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 8 | Read result byte |
| latch | output | 32 | Planar read latch |

## Verification
A read issued at one rising edge produces `rd_valid`, `rd_data` and the updated `latch` in the cycle that follows. The bench therefore drives each request at a falling edge and compares all three outputs at the next falling edge against a byte-array model that advances one request at a time. Writes produce no response of their own. Their effect, and the absence of an effect for a dropped write, is checked by later reads of the target location and of the low location that a wrapped address would hit. These reads run back to back, so a write followed at once by a read of the same word is also covered.

// File: rtl/vgm_pkg.sv
package vgm_pkg;

  typedef enum logic [1:0] {
    MAP_CHAIN4  = 2'd0,
    MAP_ODDEVEN = 2'd1,
    MAP_PLANAR  = 2'd2
  } map_mode_e;

  function automatic logic [3:0] lane_onehot(input logic [1:0] lane);
    logic [3:0] oh;
    oh = 4'b0000;
    oh[lane] = 1'b1;
    return oh;
  endfunction

endpackage

// File: rtl/vgm_xlate.sv
module vgm_xlate
  import vgm_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int RAM_WORDS = 1024,
  parameter int WA_W      = 10
) (
  input  logic              chain4_en,
  input  logic              oddeven_en,
  input  logic [1:0]        read_map,
  input  logic [3:0]        plane_we,
  input  logic [ADDR_W-1:0] addr,
  output map_mode_e         mode,
  output logic [WA_W-1:0]   word,
  output logic [1:0]        lane,
  output logic [3:0]        wr_be,
  output logic              in_range
);

  localparam logic [ADDR_W:0] WORD_LIMIT = (ADDR_W+1)'(RAM_WORDS);

  logic [ADDR_W-1:0] word_full;

  always_comb begin
    if (chain4_en) begin
      mode      = MAP_CHAIN4;
      word_full = addr >> 2;
      lane      = addr[1:0];
      wr_be     = plane_we & lane_onehot(addr[1:0]);
    end else if (oddeven_en) begin
      // byte address = {addr[N-1:1], plane}, word = addr >> 1
      mode      = MAP_ODDEVEN;
      word_full = addr >> 1;
      lane      = {read_map[1], addr[0]};
      wr_be     = plane_we & lane_onehot({1'b0, addr[0]});
    end else begin
      mode      = MAP_PLANAR;
      word_full = addr;
      lane      = read_map;
      wr_be     = plane_we;
    end
  end

  // byte address < size  <=>  word index < size/4, for every scheme
  assign in_range = ({1'b0, word_full} < WORD_LIMIT);
  assign word     = word_full[WA_W-1:0];

endmodule

// File: rtl/vgm_vram.sv
module vgm_vram #(
  parameter int WORDS = 1024,
  parameter int WA_W  = 10
) (
  input  logic            clk,
  input  logic            en,
  input  logic [3:0]      be,
  input  logic [WA_W-1:0] addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata
);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (en) begin
        if (be[k]) begin
          mem[addr] <= wdata[8*k +: 8];
        end
        q <= mem[addr];
      end
    end

    assign rdata[8*k +: 8] = q;
  end

endmodule

// File: rtl/vgm_rsp.sv
module vgm_rsp
  import vgm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_req,
  input  map_mode_e   mode,
  input  logic [1:0]  lane,
  input  logic        in_range,
  input  logic [31:0] ram_q,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic [31:0] latch
);

  logic        pend_v;
  logic        pend_planar;
  logic        pend_inr;
  logic [1:0]  pend_lane;
  logic [31:0] latch_r;
  logic        load_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v      <= 1'b0;
      pend_planar <= 1'b0;
      pend_inr    <= 1'b0;
      pend_lane   <= 2'd0;
      latch_r     <= 32'd0;
    end else begin
      pend_v      <= rd_req;
      pend_planar <= (mode == MAP_PLANAR);
      pend_inr    <= in_range;
      pend_lane   <= lane;
      latch_r     <= latch;
    end
  end

  assign load_now = pend_v && pend_planar && pend_inr;
  assign latch    = load_now ? ram_q : latch_r;
  assign rd_valid = pend_v;

  always_comb begin
    if (!pend_v) begin
      rd_data = 8'h00;
    end else if (!pend_inr) begin
      rd_data = 8'hFF;
    end else begin
      rd_data = ram_q[8*pend_lane +: 8];
    end
  end

endmodule

// File: rtl/vga_mem_mapper.sv
module vga_mem_mapper
  import vgm_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int RAM_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chain4_en,
  input  logic              oddeven_en,
  input  logic [1:0]        read_map,
  input  logic [3:0]        plane_we,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [31:0]       latch
);

  localparam int RAM_WORDS = RAM_BYTES / 4;
  localparam int WA_W      = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1;

  map_mode_e       xl_mode;
  logic [WA_W-1:0] xl_word;
  logic [1:0]      xl_lane;
  logic [3:0]      xl_be;
  logic            xl_in_range;
  logic            ram_en;
  logic [3:0]      ram_be;
  logic [31:0]     ram_q;
  logic            rd_req;

  vgm_xlate #(
    .ADDR_W   (ADDR_W),
    .RAM_WORDS(RAM_WORDS),
    .WA_W     (WA_W)
  ) u_xlate (
    .chain4_en (chain4_en),
    .oddeven_en(oddeven_en),
    .read_map  (read_map),
    .plane_we  (plane_we),
    .addr      (req_addr),
    .mode      (xl_mode),
    .word      (xl_word),
    .lane      (xl_lane),
    .wr_be     (xl_be),
    .in_range  (xl_in_range)
  );

  assign rd_req = req_valid && !req_write;
  assign ram_en = req_valid && xl_in_range;
  assign ram_be = (ram_en && req_write) ? xl_be : 4'b0000;

  vgm_vram #(
    .WORDS(RAM_WORDS),
    .WA_W (WA_W)
  ) u_vram (
    .clk  (clk),
    .en   (ram_en),
    .be   (ram_be),
    .addr (xl_word),
    .wdata({4{req_wdata}}),
    .rdata(ram_q)
  );

  vgm_rsp u_rsp (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .mode    (xl_mode),
    .lane    (xl_lane),
    .in_range(xl_in_range),
    .ram_q   (ram_q),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .latch   (latch)
  );

  AST_MODE_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    chain4_en |-> (xl_mode == MAP_CHAIN4)); // R1
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && xl_mode != MAP_PLANAR) |-> $onehot0(ram_be)); // R2
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R9
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid); // R9
  AST_OOB_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !xl_in_range) |=> (rd_valid && rd_data == 8'hFF)); // R7
  AST_OOB_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !xl_in_range) |=> $stable(latch)); // R7
  AST_OOB_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !xl_in_range) |-> !ram_en); // R8

endmodule

// File: tb/sim_vga_mem_mapper.sv
`timescale 1ns/1ps
module sim_vga_mem_mapper;
  localparam int AW = 14;
  localparam int RB = 4096;
  localparam int RW = RB / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          c4 = 1'b0, oe = 1'b0;
  logic [1:0]    rm = 2'd0;
  logic [3:0]    pwe = 4'hF;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = 8'h00;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic [31:0]   latch;

  logic [7:0]  m [RB];
  int          n_vec = 0, n_bad = 0;
  logic        exp_v = 1'b0;
  logic [7:0]  exp_d = 8'h00;
  logic [31:0] exp_l = 32'h0;
  int          seed = 12345;

  vga_mem_mapper #(.ADDR_W(AW), .RAM_BYTES(RB)) u0 (
    .clk(clk), .rst(rst), .chain4_en(c4), .oddeven_en(oe), .read_map(rm),
    .plane_we(pwe), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .latch(latch));

  task automatic chk(input string r);
    n_vec++;
    if (rd_valid !== exp_v || (exp_v && rd_data !== exp_d) || latch !== exp_l) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b data=%02h latch=%08h, expected valid=%0b data=%02h latch=%08h",
               r, rd_valid, rd_data, latch, exp_v, exp_d, exp_l);
    end
  endtask

  // drive one request at a falling edge, check its result one cycle later
  task automatic op(input bit w, input int a, input logic [7:0] d, input string r);
    int  phys;
    int  pl;
    bit  inr;
    req_valid = 1'b1; req_write = w; req_addr = a[AW-1:0]; req_wdata = d;
    exp_v = !w; exp_d = 8'hFF;
    if (c4) begin
      phys = a; inr = (phys < RB);
      if (w) begin
        if (inr && pwe[a % 4]) m[phys] = d;
      end else if (inr) exp_d = m[phys];
    end else if (oe) begin
      pl = w ? (a % 2) : ((int'(rm) & 2) | (a % 2));
      phys = (a / 2) * 4 + pl; inr = (phys < RB);
      if (w) begin
        if (inr && pwe[a % 2]) m[phys] = d;
      end else if (inr) exp_d = m[phys];
    end else begin
      inr = (a * 4 < RB);
      if (w) begin
        if (inr) for (int k = 0; k < 4; k++) if (pwe[k]) m[a*4+k] = d;
      end else if (inr) begin
        exp_l = {m[a*4+3], m[a*4+2], m[a*4+1], m[a*4]};
        exp_d = m[a*4 + int'(rm)];
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(r);
  endtask

  task automatic idle(input string r);
    exp_v = 1'b0;
    @(negedge clk);
    chk(r);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R9 watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 in reset");
    rst = 1'b0;
    idle("R10 after reset");

    // R2 fill through chained writes
    c4 = 1'b1; oe = 1'b0; pwe = 4'hF;
    for (int a = 0; a < RB; a++) op(1'b1, a, 8'((a * 37 + 11) & 255), "R2 fill");
    op(1'b0, 0, 8'h00, "R2 read 0");
    op(1'b0, 5, 8'h00, "R2 read 5");
    op(1'b0, RB - 1, 8'h00, "R2 last valid");
    op(1'b0, RB, 8'h00, "R7 chained first invalid");
    op(1'b0, (1 << AW) - 1, 8'h00, "R7 chained top");
    idle("R9 no read");

    // R2 plane gating
    pwe = 4'b0101;
    op(1'b1, 1, 8'hA5, "R2 gated write");
    op(1'b1, 2, 8'h5A, "R2 enabled write");
    op(1'b0, 1, 8'h00, "R2 gated readback");
    op(1'b0, 2, 8'h00, "R2 enabled readback");

    // R8 chained out of range must not wrap onto byte 0
    pwe = 4'hF;
    op(1'b1, RB, 8'h77, "R8 chained oob write");
    op(1'b0, 0, 8'h00, "R8 chained no wrap");

    // R1 priority
    oe = 1'b1; rm = 2'd2;
    op(1'b0, 6, 8'h00, "R1 chained wins");

    // R3 odd/even reads
    c4 = 1'b0; rm = 2'd0;
    op(1'b0, 6, 8'h00, "R3 even rm0");
    op(1'b0, 7, 8'h00, "R3 odd rm0");
    rm = 2'd2;
    op(1'b0, 6, 8'h00, "R3 even rm2");
    op(1'b0, 7, 8'h00, "R3 odd rm2");
    op(1'b0, 2047, 8'h00, "R3 last valid");
    rm = 2'd0;
    op(1'b0, 2048, 8'h00, "R7 odd/even first invalid");

    // R4 odd/even writes
    pwe = 4'b0010;
    op(1'b1, 10, 8'hC3, "R4 gated write");
    op(1'b1, 11, 8'h3C, "R4 enabled write");
    op(1'b0, 10, 8'h00, "R4 gated readback");
    op(1'b0, 11, 8'h00, "R4 enabled readback");
    pwe = 4'hF;
    op(1'b1, 2048, 8'h99, "R8 odd/even oob write");
    op(1'b0, 0, 8'h00, "R8 odd/even no wrap");

    // R5 planar reads and latch
    oe = 1'b0; rm = 2'd1;
    op(1'b0, 3, 8'h00, "R5 planar read");
    rm = 2'd3;
    op(1'b0, RW - 1, 8'h00, "R5 last valid word");
    op(1'b0, RW, 8'h00, "R7 planar first invalid keeps latch");
    op(1'b0, (1 << AW) - 1, 8'h00, "R7 planar top");

    // R6 planar masked write, then immediate read of same word
    pwe = 4'b1001;
    op(1'b1, 5, 8'h3C, "R6 masked write");
    rm = 2'd0;
    op(1'b0, 5, 8'h00, "R6 readback");
    pwe = 4'hF;
    op(1'b1, RW, 8'hEE, "R8 planar oob write");
    op(1'b0, 0, 8'h00, "R8 planar no wrap");

    // R9 mixed back-to-back traffic
    for (int i = 0; i < 400; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      c4  = (seed[3:2] == 2'd0);
      oe  = seed[4];
      rm  = seed[6:5];
      pwe = seed[10:7];
      op(seed[11] & seed[12], (seed >> 13) % (RB + 64), 8'(seed >> 20), "R9 mixed");
    end
    idle("R9 idle after traffic");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule